// File: doc/BRIEF.md
# Dual-View General Register Bank

This block holds the thirty-two 8-bit working registers of a small processor core. The registers feed the adder directly from a 16-bit instruction word. The same storage also answers on the data-space bus at the lowest thirty-two byte addresses. An instruction word is decoded combinationally. If it is the two-register add, both operands are read, summed and written back to the destination register on the next rising edge, and the carry-out is captured on that same edge.

Data-bus accesses that fall below address 32 reach the register storage. Every other address is forwarded untouched to an external memory port. That port has its own read and write strobes, and its read data is returned on the bus.

A third read path serves instruction formats that carry only a 4-bit register number. That number always selects from the upper sixteen registers.

Top module: `gpr_bank_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 32 registers and `carry_q` to zero.
- R2: A bus write (`bus_wr`=1) to an address from 0 to 31 stores `bus_wdata` into the register of that number at the rising edge. A bus read of such an address returns that register on `bus_rdata` combinationally.
- R3: An instruction is an add only when `instr_valid`=1 and `instr[15:10]`=6'b000011. The destination number is `instr[8:4]`. The source number is `instr[9]` concatenated above `instr[3:0]`.
- R4: An add writes (dest+source) mod 256 into the destination register, in the same single edge as the read. `carry_q` takes bit 8 of the 9-bit sum on that edge and holds its value when no add occurs.
- R5: A bus access at an address of 32 or more does not touch the registers. It drives `ext_addr`=`bus_addr`, `ext_wdata`=`bus_wdata`, `ext_wr`=`bus_wr` and `ext_rd`=`bus_rd`, and returns `ext_rdata` on `bus_rdata`. Accesses below 32 keep `ext_wr` and `ext_rd` low.
- R6: A register read in the cycle after a bus write returns the newly written value.
- R7: When an add and a bus write target the same register in one cycle, the add result is stored. When they target different registers, both are stored.
- R8: A word with `instr_valid`=0, or with any other value in bits 15:10, changes neither the registers nor `carry_q`.
- R9: `upper_data` returns register 16+`upper_sel` combinationally, for a 4-bit `upper_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| upper_sel | input | 4 | Short register number (upper half) |
| upper_data | output | 8 | Register 16+upper_sel |
| bus_addr | input | 16 | Data-space byte address |
| bus_rd | input | 1 | Data-bus read strobe |
| bus_wr | input | 1 | Data-bus write strobe |
| bus_wdata | input | 8 | Data-bus write data |
| bus_rdata | output | 8 | Data-bus read data |
| ext_addr | output | 16 | Address forwarded to external RAM |
| ext_rd | output | 1 | External RAM read strobe |
| ext_wr | output | 1 | External RAM write strobe |
| ext_wdata | output | 8 | External RAM write data |
| ext_rdata | input | 8 | External RAM read data |
| carry_q | output | 1 | Registered carry of the last add |

## Verification
The bench builds the block with its default parameters: 32 registers, 8-bit data and a 16-bit address. At that size every destination/source pair of the add, including a register added to itself, can be swept: all 1024 pairs run in sequence against an arithmetic model. Every register is also written and read through the bus, and every short register number is read. The remaining cases are the boundary addresses 31 and 32, the top of the address space, same-register and different-register collisions between the two write sources, rejected instruction words, and a reset in the middle of the run.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int unsigned GPR_IDXW = 5;
    localparam logic [5:0] ADD_OPCODE = 6'b000011;

    typedef struct packed {
        logic                hit;
        logic [GPR_IDXW-1:0] dst;
        logic [GPR_IDXW-1:0] src;
    } add_dec_t;
endpackage

// File: rtl/gpr_add_decode.sv
module gpr_add_decode
    import gpr_pkg::*;
(
    input  logic        instr_valid,
    input  logic [15:0] instr,
    output add_dec_t    dec
);
    // Destination field is contiguous; source field is split around it.
    always_comb begin
        dec.hit = instr_valid && (instr[15:10] == ADD_OPCODE);
        dec.dst = instr[8:4];
        dec.src = {instr[9], instr[3:0]};
    end
endmodule

// File: rtl/gpr_bus_map.sv
module gpr_bus_map #(
    parameter int unsigned AW   = 16,
    parameter int unsigned NREG = 32
) (
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    output logic          reg_hit,
    output logic          reg_we,
    output logic          ext_rd,
    output logic          ext_wr
);
    localparam logic [AW-1:0] REG_LIMIT = AW'(NREG);

    always_comb begin
        reg_hit = (bus_addr < REG_LIMIT);
        reg_we  = reg_hit && bus_wr;
        ext_wr  = !reg_hit && bus_wr;
        ext_rd  = !reg_hit && bus_rd;
    end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
    parameter int unsigned NREG = 32,
    parameter int unsigned DW   = 8,
    parameter int unsigned NRD  = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NRD-1:0][$clog2(NREG)-1:0] rd_idx,
    output logic [NRD-1:0][DW-1:0]           rd_data,
    input  logic                             alu_we,
    input  logic [$clog2(NREG)-1:0]          alu_idx,
    input  logic [DW-1:0]                    alu_data,
    input  logic                             alu_carry,
    input  logic                             bus_we,
    input  logic [$clog2(NREG)-1:0]          bus_idx,
    input  logic [DW-1:0]                    bus_data,
    output logic                             carry_q
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic                    carry;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            st_d.regs[bus_idx] = bus_data;
        end
        // Arithmetic write-back comes last so it wins a same-register clash.
        if (alu_we) begin
            st_d.regs[alu_idx] = alu_data;
            st_d.carry         = alu_carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = st_q.regs[rd_idx[p]];
    end

    assign carry_q = st_q.carry;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (st_q.regs == '0 && st_q.carry == 1'b0));

    assert_bus_store_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !(alu_we && alu_idx == bus_idx))
        |=> st_q.regs[$past(bus_idx)] == $past(bus_data));

    assert_alu_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (alu_we && bus_we && alu_idx == bus_idx)
        |=> st_q.regs[$past(alu_idx)] == $past(alu_data));
endmodule

// File: rtl/gpr_bank_top.sv
module gpr_bank_top
    import gpr_pkg::*;
#(
    parameter int unsigned NREG = 32,
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      instr_valid,
    input  logic [15:0]               instr,
    input  logic [$clog2(NREG)-2:0]   upper_sel,
    output logic [DW-1:0]             upper_data,
    input  logic [AW-1:0]             bus_addr,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    output logic [AW-1:0]             ext_addr,
    output logic                      ext_rd,
    output logic                      ext_wr,
    output logic [DW-1:0]             ext_wdata,
    input  logic [DW-1:0]             ext_rdata,
    output logic                      carry_q
);
    localparam int unsigned IDXW = $clog2(NREG);
    localparam int unsigned NRD  = 4;
    localparam int unsigned P_DST = 0;
    localparam int unsigned P_SRC = 1;
    localparam int unsigned P_BUS = 2;
    localparam int unsigned P_UPR = 3;

    add_dec_t                   dec;
    logic                       reg_hit, reg_we;
    logic [NRD-1:0][IDXW-1:0]   rd_idx;
    logic [NRD-1:0][DW-1:0]     rd_data;
    logic [DW:0]                sum;

    gpr_add_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .dec         (dec)
    );

    gpr_bus_map #(.AW(AW), .NREG(NREG)) u_map (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .reg_hit  (reg_hit),
        .reg_we   (reg_we),
        .ext_rd   (ext_rd),
        .ext_wr   (ext_wr)
    );

    always_comb begin
        rd_idx[P_DST] = dec.dst;
        rd_idx[P_SRC] = dec.src;
        rd_idx[P_BUS] = bus_addr[IDXW-1:0];
        rd_idx[P_UPR] = {1'b1, upper_sel};
        sum           = {1'b0, rd_data[P_DST]} + {1'b0, rd_data[P_SRC]};
    end

    gpr_storage #(.NREG(NREG), .DW(DW), .NRD(NRD)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .alu_we    (dec.hit),
        .alu_idx   (dec.dst),
        .alu_data  (sum[DW-1:0]),
        .alu_carry (sum[DW]),
        .bus_we    (reg_we),
        .bus_idx   (bus_addr[IDXW-1:0]),
        .bus_data  (bus_wdata),
        .carry_q   (carry_q)
    );

    assign ext_addr   = bus_addr;
    assign ext_wdata  = bus_wdata;
    assign bus_rdata  = reg_hit ? rd_data[P_BUS] : ext_rdata;
    assign upper_data = rd_data[P_UPR];

    assert_add_carry_R4: assert property (@(posedge clk) disable iff (rst)
        dec.hit |=> carry_q == $past(sum[DW]));

    assert_carry_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |=> $stable(carry_q));

    always_comb begin
        assert_one_target_R5: assert (!(reg_we && ext_wr));
    end
endmodule

// File: tb/test_gpr_bank_top.sv
`timescale 1ns/1ps
module test_gpr_bank_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        instr_valid = 0;
    logic [15:0] instr = '0;
    logic [3:0]  upper_sel = '0;
    logic [7:0]  upper_data;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic [15:0] ext_addr;
    logic        ext_rd, ext_wr;
    logic [7:0]  ext_wdata, ext_rdata = '0;
    logic        carry_q;

    int total = 0, bad = 0;
    logic [7:0] m [32];
    logic       mc;

    always #5 clk = ~clk;

    gpr_bank_top i_gpr_bank_top (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .upper_sel(upper_sel), .upper_data(upper_data),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .carry_q(carry_q)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] add_word(input int d, input int r);
        logic [4:0] dd = 5'(d);
        logic [4:0] rr = 5'(r);
        return {6'b000011, rr[4], dd, rr[3:0]};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
        instr_valid = 0; bus_wr = 0; bus_rd = 0;
    endtask

    task automatic rdreg(input int i, output logic [7:0] v);
        bus_addr = 16'(i); bus_rd = 1;
        #0.1;
        v = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int i = 0; i < 32; i++) begin
            rdreg(i, v);
            chk(req, v, m[i]);
        end
        chk(req, carry_q, mc);
    endtask

    task automatic do_add(input int d, input int r);
        logic [8:0] s;
        s = {1'b0, m[d]} + {1'b0, m[r]};
        instr = add_word(d, r); instr_valid = 1;
        step();
        m[d] = s[7:0]; mc = s[8];
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 32; i++) m[i] = 8'h0;
        mc = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check_all("R1 reset");

        // R2 / R6: write every register via the bus, read back next cycle
        for (int i = 0; i < 32; i++) begin
            bus_addr = 16'(i); bus_wdata = 8'(i * 37 + 11); bus_wr = 1;
            #0.1 chk("R5 no ext_wr below 32", ext_wr, 0);
            step();
            m[i] = 8'(i * 37 + 11);
            rdreg(i, v);
            chk("R6 read after write", v, m[i]);
        end
        check_all("R2 bus store");

        // R5: boundary and top of address space
        bus_addr = 16'd32; bus_wdata = 8'h5A; bus_wr = 1; bus_rd = 0;
        #0.1;
        chk("R5 ext_wr at 32", ext_wr, 1);
        chk("R5 ext_addr", ext_addr, 32);
        chk("R5 ext_wdata", ext_wdata, 8'h5A);
        step();
        check_all("R5 regs untouched");
        bus_addr = 16'hFFFF; bus_wdata = 8'hA5; bus_wr = 1;
        step();
        check_all("R5 regs untouched top");
        bus_addr = 16'h1234; bus_rd = 1; ext_rdata = 8'hC3;
        #0.1;
        chk("R5 ext_rd", ext_rd, 1);
        chk("R5 rdata passthrough", bus_rdata, 8'hC3);
        bus_addr = 16'd31;
        #0.1;
        chk("R5 ext_rd low at 31", ext_rd, 0);
        chk("R5 reg 31 read", bus_rdata, m[31]);
        bus_rd = 0;

        // R9: short register numbers
        for (int s = 0; s < 16; s++) begin
            upper_sel = 4'(s);
            #0.1 chk("R9 upper port", upper_data, m[16 + s]);
        end

        // R4: explicit carry case
        bus_addr = 16'd2; bus_wdata = 8'hFF; bus_wr = 1; step(); m[2] = 8'hFF;
        bus_addr = 16'd20; bus_wdata = 8'h01; bus_wr = 1; step(); m[20] = 8'h01;
        do_add(2, 20);
        rdreg(2, v);
        chk("R4 wrap sum", v, 0);
        chk("R4 carry set", carry_q, 1);

        // R3 / R4: every destination/source pair
        for (int d = 0; d < 32; d++) begin
            for (int r = 0; r < 32; r++) begin
                do_add(d, r);
                rdreg(d, v);
                chk("R3 R4 add sweep", v, m[d]);
                chk("R4 carry", carry_q, mc);
            end
        end
        check_all("R4 after sweep");

        // R8: rejected words
        instr = add_word(5, 6); instr_valid = 0;
        step();
        check_all("R8 valid low");
        for (int op = 0; op < 64; op++) begin
            if (op != 3) begin
                instr = {6'(op), 10'h1A5}; instr_valid = 1;
                step();
            end
        end
        check_all("R8 other opcodes");

        // R7: collision on the same register, then on different ones
        begin
            logic [8:0] s;
            s = {1'b0, m[9]} + {1'b0, m[10]};
            instr = add_word(9, 10); instr_valid = 1;
            bus_addr = 16'd9; bus_wdata = 8'h11; bus_wr = 1;
            step();
            m[9] = s[7:0]; mc = s[8];
            check_all("R7 alu wins");
            s = {1'b0, m[4]} + {1'b0, m[17]};
            instr = add_word(4, 17); instr_valid = 1;
            bus_addr = 16'd3; bus_wdata = 8'h77; bus_wr = 1;
            step();
            m[4] = s[7:0]; mc = s[8]; m[3] = 8'h77;
            check_all("R7 both stored");
        end

        // R1: reset mid-run
        rst = 1;
        step();
        rst = 0;
        for (int i = 0; i < 32; i++) m[i] = 8'h0;
        mc = 0;
        check_all("R1 mid-run reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule